// File: doc/BRIEF.md
# Erase Sector Select Register

This block is a 32-bit control register that records which flash sectors a later erase will act on. Software writes it over a simple register bus with an address, a write strobe, write data and registered read data. The erase controller reads the selection from a dedicated vector output, `sel_vec`, where bit i stands for sector i. It also drives three sideband inputs. `ilk_wr_pulse` marks that the erase interlock write has completed. `hv_suspended` is held high while a high-voltage operation is paused. `erase_end` reports that the erase has finished or been aborted.

Only two fields of the register hold state. A low-space field covers sectors 5..0 and a mid-space field covers sectors 7..6. Every other bit reads 0 and ignores writes. A sector that the build does not provide is marked by a 0 in the `PRESENT_MASK` parameter and has no storage, so its bit is always 0. Writes are refused from the interlock pulse until the erase ends, and also for as long as a high-voltage operation is suspended.

Top module: `erase_sector_sel`

## Requirements
- R1: While `rst` is high at a clock edge, every select bit, the write lock and `bus_rdata` are cleared to 0 at that edge.
- R2: A write (`bus_we`=1, `bus_addr`=`REG_ADDR`, default 8'h10) that is not blocked updates `sel_vec` at the same clock edge. A 1 selects the sector and a 0 deselects it.
- R3: Register bits 5:0 map to sectors 5..0 (`sel_vec[5:0]`). Register bit 16 maps to sector 6 and register bit 17 maps to sector 7 (`sel_vec[7:6]`).
- R4: Register bits 31:18 and 15:6 always read 0, and writing them changes nothing.
- R5: A sector whose `PRESENT_MASK` bit is 0 keeps its select bit at 0 and ignores writes. The default mask is 8'hDF, so sector 5 (register bit 5) is absent.
- R6: An `ilk_wr_pulse` sets the write lock. While the lock is set, writes are ignored. The lock clears at the edge after the one where `erase_end` is seen. Reset also clears it.
- R7: A write in the same cycle as `ilk_wr_pulse` is ignored. If `ilk_wr_pulse` and `erase_end` arrive together, the lock is still set.
- R8: A write in any cycle with `hv_suspended` high is ignored.
- R9: `bus_rdata` is registered. At each edge it takes the register image when `bus_addr` equals `REG_ADDR`, and 0 for any other address. The image reflects the selection held before that edge's write.
- R10: A write to any address other than `REG_ADDR` leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ilk_wr_pulse | input | 1 | Erase interlock write completed (one-cycle pulse) |
| hv_suspended | input | 1 | High-voltage operation suspended (level) |
| erase_end | input | 1 | Erase finished or aborted (pulse) |
| sel_vec | output | 8 | Selected-sector vector, bit i = sector i |

## Verification
Suppose the lock tracker holds a wrong state. Then a write that should be accepted or refused lands or vanishes, and the error shows on `sel_vec` one edge after that write. Suppose a field is mapped wrongly or a storage bit wrongly exists for an absent sector. Then the fault shows on `sel_vec` right after the write, and on `bus_rdata` one edge after the address is presented. The checks therefore sample `sel_vec` one cycle after each write attempt and `bus_rdata` one cycle after each read address, so any fault surfaces within two cycles of the stimulus that exposes it.

// File: rtl/esel_pkg.sv
package esel_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_e;
endpackage

// File: rtl/esel_lock_ctl.sv
module esel_lock_ctl
  import esel_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  arm_i,
  input  logic  susp_i,
  input  logic  release_i,
  output lock_e state_o,
  output logic  wr_block_o
);
  lock_e state_q;

  // arming wins over release when both arrive together
  always_ff @(posedge clk) begin
    if (rst)            state_q <= LK_OPEN;
    else if (arm_i)     state_q <= LK_HELD;
    else if (release_i) state_q <= LK_OPEN;
  end

  assign state_o    = state_q;
  assign wr_block_o = (state_q == LK_HELD) | arm_i | susp_i;
endmodule

// File: rtl/esel_bit_store.sv
module esel_bit_store #(
  parameter int unsigned            N_SECT       = 8,
  parameter logic [N_SECT-1:0]      PRESENT_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [N_SECT-1:0] wr_sect,
  output logic [N_SECT-1:0] sel_o
);
  logic [N_SECT-1:0] unused_absent;
  assign unused_absent = wr_sect & ~PRESENT_MASK;

  for (genvar g = 0; g < N_SECT; g++) begin : g_sect
    if (PRESENT_MASK[g]) begin : g_have
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)        bit_q <= 1'b0;
        else if (wr_en) bit_q <= wr_sect[g];
      end
      assign sel_o[g] = bit_q;
    end else begin : g_none
      assign sel_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/esel_read_port.sv
module esel_read_port
  import esel_pkg::*;
#(
  parameter int unsigned N_LOW   = 6,
  parameter int unsigned N_MID   = 2,
  parameter int unsigned MID_LSB = 16,
  localparam int unsigned N_SECT = N_LOW + N_MID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [N_SECT-1:0] sel_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] image;

  always_comb begin
    image = '0;
    image[N_LOW-1:0]        = sel_i[N_LOW-1:0];
    image[MID_LSB +: N_MID] = sel_i[N_SECT-1:N_LOW];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= hit_i ? image : '0;
  end
endmodule

// File: rtl/erase_sector_sel.sv
module erase_sector_sel
  import esel_pkg::*;
#(
  parameter int unsigned            ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]      REG_ADDR     = 8'h10,
  parameter int unsigned            N_LOW        = 6,
  parameter int unsigned            N_MID        = 2,
  parameter int unsigned            MID_LSB      = 16,
  parameter logic [N_LOW+N_MID-1:0] PRESENT_MASK = 8'hDF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  input  logic                    ilk_wr_pulse,
  input  logic                    hv_suspended,
  input  logic                    erase_end,
  output logic [N_LOW+N_MID-1:0]  sel_vec
);
  localparam int unsigned N_SECT = N_LOW + N_MID;

  logic              hit;
  logic              wr_block;
  logic              wr_en;
  lock_e             lock_state;
  logic [N_SECT-1:0] wr_sect;
  logic [REG_W-1:0]  unused_wbits;

  assign hit          = (bus_addr == REG_ADDR);
  assign wr_sect      = {bus_wdata[MID_LSB +: N_MID], bus_wdata[N_LOW-1:0]};
  assign unused_wbits = bus_wdata;
  assign wr_en        = bus_we & hit & ~wr_block;

  esel_lock_ctl u_lock (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (ilk_wr_pulse),
    .susp_i     (hv_suspended),
    .release_i  (erase_end),
    .state_o    (lock_state),
    .wr_block_o (wr_block)
  );

  esel_bit_store #(
    .N_SECT       (N_SECT),
    .PRESENT_MASK (PRESENT_MASK)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sect (wr_sect),
    .sel_o   (sel_vec)
  );

  esel_read_port #(
    .N_LOW   (N_LOW),
    .N_MID   (N_MID),
    .MID_LSB (MID_LSB)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (hit),
    .sel_i   (sel_vec),
    .rdata_o (bus_rdata)
  );
endmodule

// File: rtl/esel_chk.sv
module esel_chk #(
  parameter int unsigned            ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]      REG_ADDR     = 8'h10,
  parameter int unsigned            N_LOW        = 6,
  parameter int unsigned            N_MID        = 2,
  parameter int unsigned            MID_LSB      = 16,
  parameter logic [N_LOW+N_MID-1:0] PRESENT_MASK = 8'hDF
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_we,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic                   ilk_wr_pulse,
  input logic                   hv_suspended,
  input logic                   lock_q,
  input logic [N_LOW+N_MID-1:0] sel_vec
);
  logic [N_LOW+N_MID-1:0] want;
  logic [31:0]            img;
  logic [31:0]            unused_chk;
  logic                   open_wr;

  assign want       = {bus_wdata[MID_LSB +: N_MID], bus_wdata[N_LOW-1:0]} & PRESENT_MASK;
  assign unused_chk = bus_wdata;
  assign open_wr    = bus_we && (bus_addr == REG_ADDR) && !lock_q && !ilk_wr_pulse && !hv_suspended;

  always_comb begin
    img = '0;
    img[N_LOW-1:0]        = sel_vec[N_LOW-1:0];
    img[MID_LSB +: N_MID] = sel_vec[N_LOW+N_MID-1:N_LOW];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sel_vec == '0 && bus_rdata == '0 && !lock_q));
  // R2
  write_take_chk: assert property (@(posedge clk) disable iff (rst) open_wr |=> sel_vec == $past(want));
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst) lock_q |=> $stable(sel_vec));
  // R7
  pulse_arm_chk: assert property (@(posedge clk) disable iff (rst) ilk_wr_pulse |=> (lock_q && $stable(sel_vec)));
  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst) hv_suspended |=> $stable(sel_vec));
  // R9
  read_img_chk: assert property (@(posedge clk) disable iff (rst) (bus_addr == REG_ADDR) |=> bus_rdata == $past(img));
  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (rst) (bus_addr != REG_ADDR) |=> $stable(sel_vec));
endmodule

bind erase_sector_sel esel_chk #(
  .ADDR_W       (ADDR_W),
  .REG_ADDR     (REG_ADDR),
  .N_LOW        (N_LOW),
  .N_MID        (N_MID),
  .MID_LSB      (MID_LSB),
  .PRESENT_MASK (PRESENT_MASK)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .ilk_wr_pulse (ilk_wr_pulse),
  .hv_suspended (hv_suspended),
  .lock_q       (lock_state),
  .sel_vec      (sel_vec)
);

// File: tb/tb_erase_sector_sel.sv
module tb_erase_sector_sel;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ilk_wr_pulse;
  logic        hv_suspended;
  logic        erase_end;
  logic [7:0]  sel_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  erase_sector_sel dut (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ilk_wr_pulse (ilk_wr_pulse),
    .hv_suspended (hv_suspended),
    .erase_end    (erase_end),
    .sel_vec      (sel_vec)
  );

  // {wdata, ilk, hv, end, expected sel_vec after the edge}; all writes to 8'h10
  typedef struct packed {
    logic [31:0] wd;
    logic        ilk;
    logic        hv;
    logic        fin;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{32'h0000_003F, 1'b0, 1'b0, 1'b0, 8'h1F}, // R3 R5 low field, sector 5 absent
    '{32'h0003_0000, 1'b0, 1'b0, 1'b0, 8'hC0}, // R3 mid field
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 8'hDF}, // R2 R5 all ones
    '{32'h0000_0001, 1'b0, 1'b1, 1'b0, 8'hDF}, // R8 suspended
    '{32'h0000_0002, 1'b0, 1'b0, 1'b0, 8'h02}, // R2 back open
    '{32'h0002_0004, 1'b1, 1'b0, 1'b0, 8'h02}, // R7 same-cycle pulse
    '{32'h0000_0008, 1'b0, 1'b0, 1'b0, 8'h02}, // R6 locked
    '{32'h0000_0010, 1'b0, 1'b0, 1'b1, 8'h02}, // R6 release cycle still locked
    '{32'h0001_0010, 1'b0, 1'b0, 1'b0, 8'h50}, // R6 R3 reopened, bit16 -> sector 6
    '{32'h0002_0000, 1'b1, 1'b0, 1'b1, 8'h50}, // R7 pulse beats release
    '{32'h0000_0001, 1'b0, 1'b0, 1'b0, 8'h50}, // R7 still locked
    '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 8'h50}, // R6 release
    '{32'h0000_FFC1, 1'b0, 1'b0, 1'b0, 8'h01}  // R4 unused bits dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] wd,
                     input logic ilk, input logic hv, input logic fin);
    bus_addr = a; bus_we = we; bus_wdata = wd;
    ilk_wr_pulse = ilk; hv_suspended = hv; erase_end = fin;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; ilk_wr_pulse = 1'b0; hv_suspended = 1'b0; erase_end = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = '0;
    ilk_wr_pulse = 1'b0; hv_suspended = 1'b0; erase_end = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sel_vec after reset", {24'h0, sel_vec}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(8'h10, 1'b1, VT[i].wd, VT[i].ilk, VT[i].hv, VT[i].fin);
      chk($sformatf("R2 table row %0d", i), {24'h0, sel_vec}, {24'h0, VT[i].exp});
    end

    // R9 read image: sel=0x01 -> image 0x00000001
    cyc(8'h10, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R9 read low image", bus_rdata, 32'h0000_0001);
    // R9 registered read reflects pre-write value
    cyc(8'h10, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R9 read shows old value", bus_rdata, 32'h0000_0001);
    chk("R5 sel all ones", {24'h0, sel_vec}, 32'h0000_00DF);
    cyc(8'h10, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R4 R3 read full image", bus_rdata, 32'h0003_001F);
    // R9 other address reads 0
    cyc(8'h14, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R9 other address reads 0", bus_rdata, 32'h0);
    // R10 write to other address ignored
    cyc(8'h14, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R10 foreign write ignored", {24'h0, sel_vec}, 32'h0000_00DF);
    // R1 R6 reset clears lock
    cyc(8'h10, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    cyc(8'h10, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R6 locked before reset", {24'h0, sel_vec}, 32'h0000_00DF);
    rst = 1'b1;
    cyc(8'h10, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    chk("R1 sel cleared by reset", {24'h0, sel_vec}, 32'h0);
    cyc(8'h10, 1'b1, 32'h0002_0000, 1'b0, 1'b0, 1'b0);
    chk("R1 R6 lock cleared by reset", {24'h0, sel_vec}, 32'h0000_0080);
    cyc(8'h10, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R3 bit17 is sector 7", bus_rdata, 32'h0002_0000);

    finish_run();
  end
endmodule